// File: doc/BRIEF.md
# Nested Prioritized Event Controller

This block is the event controller that sits beside a small processor core. It collects every event that can redirect the core into one 16-level priority space. Level 0 ranks highest. The event sources are emulation, a reset event, a nonmaskable interrupt, a synchronous exception, a hardware error, the core timer, seven peripheral levels and two software-only levels. The controller latches each request as pending and applies a per-level enable mask. It then selects the best pending level that strictly outranks everything already in service, and it announces that entry with the level number. Each level has its own return-address slot. A return strobe retires the most recently entered level, so nested service unwinds in order.

Peripheral request lines do not map to fixed levels. They pass through a routing table that assigns each source to one of the peripheral levels 7..13. The table loads a default at reset, and software may rewrite it. Levels 14 and 15 are raised only by software strobes. Level 4 is a reserved slot and is never raised.

A small state machine tracks whether the core is idle or in service. `S_IDLE` moves to `S_NEST` on the transition `T_ENTER`, which is the first entry. `S_NEST` stays in `S_NEST` on `T_DEEPER` (a further nested entry) and on `T_UNWIND` (a return that leaves other levels active). `S_NEST` moves back to `S_IDLE` on `T_DONE`, which is a return that retires the last active level.

Top module: `evt_nest_ctrl`

## Requirements
- R1: While rst_n is low, all pending and active bits clear, every maskable level is disabled and the routing table loads its default. After release, evt_take and in_service are 0 until a request arrives.
- R2: A request sets the pending bit of its level at the next clock edge. The mapping is emu_req→0, rst_evt_req→1, nmi_pin OR wdog_expire→2, exc_req→3, hwerr_req→5, tmr_req→6, routed peripheral lines→7..13, swi_raise[0]→14 and swi_raise[1]→15. Level 4 never becomes pending or active.
- R3: A write on mask_we loads bit L of mask_wdata as the enable of level L for L in 5..15, where 1 means enabled. Bits 0..4 of the write are ignored, and levels 0..3 are always enabled. A pending level that is masked stays pending and is entered once it is enabled.
- R4: evt_take and evt_level show the chosen entry combinationally in the cycle after the request edge. The chosen level is the lowest-numbered pending, enabled level that is strictly lower in number than every active level. At most one level is entered per clock edge.
- R5: At the edge where evt_take is high, the entered level becomes active and its pending bit clears. A new request for that level in the same cycle keeps it pending. ret_addr_in is also stored in that level's slot.
- R6: rfe retires the lowest-numbered active level at the next edge, and no entry is made in that cycle. rfe is ignored when nothing is active.
- R7: ret_addr_out shows the slot of the lowest-numbered active level, and 0 when no level is active.
- R8: A request for a level that is already active stays pending. It is entered only after that level has been retired.
- R9: kill_insn is high in exactly the cycles in which exc_req is high.
- R10: With the default routing, source i is routed to level 7 + (i mod 7). A write with cfg_we routes source cfg_src to level cfg_level when cfg_level is in 7..13. Writes with any other cfg_level are ignored.
- R11: in_service is high exactly when at least one level is active. It corresponds to state S_NEST, while S_IDLE means no level is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| emu_req | input | 1 | Emulation event request (level 0) |
| rst_evt_req | input | 1 | Reset event request (level 1) |
| nmi_pin | input | 1 | External nonmaskable request (level 2) |
| wdog_expire | input | 1 | Watchdog timeout request (level 2) |
| exc_req | input | 1 | Synchronous exception request (level 3) |
| hwerr_req | input | 1 | Hardware error request (level 5) |
| tmr_req | input | 1 | Core timer request (level 6) |
| periph_req | input | NUM_SRC | Peripheral request lines, routed to levels 7..13 |
| swi_raise | input | 2 | Software raise strobes for levels 14 and 15 |
| mask_we | input | 1 | Mask register write strobe |
| mask_wdata | input | 16 | Mask write data, one enable bit per level |
| cfg_we | input | 1 | Routing table write strobe |
| cfg_src | input | SRC_W | Source index to reroute |
| cfg_level | input | 4 | Target level for the rerouted source |
| rfe | input | 1 | Return-from-event strobe |
| ret_addr_in | input | ADDR_W | Return address captured on entry |
| evt_take | output | 1 | An entry happens at the next edge |
| evt_level | output | 4 | Level being entered |
| kill_insn | output | 1 | Faulting instruction must not complete |
| in_service | output | 1 | At least one level is active |
| active_vec | output | 16 | Active level bits |
| pending_vec | output | 16 | Pending level bits |
| ret_addr_out | output | ADDR_W | Return address of the current top level |

## Verification
Several rules are checked by assertions on every cycle. Any entry must strictly outrank every active level and must name an enabled level. An entry must set its active bit and clear its pending bit. A return must lower the active count by exactly one. Level 4 must stay silent, and the state machine must agree with the active set. The bench scenarios cover what the assertions cannot. These are the exact order in which stacked requests are served, which includes a masked level that is held and later released. They also cover a same-level request that waits for unwinding, the return addresses presented while levels nest and unwind, and the effect of accepted and rejected routing writes on which level a peripheral reaches.

// File: rtl/evt_pkg.sv
package evt_pkg;
    localparam int NLVL    = 16;
    localparam int LVL_W   = 4;
    localparam int PER_LO  = 7;
    localparam int PER_HI  = 13;
    localparam int NPER    = PER_HI - PER_LO + 1;
    localparam int OFS_W   = 3;

    typedef logic [NLVL-1:0] lvl_vec_t;

    localparam lvl_vec_t ALWAYS_ON = 16'h000F;
    localparam lvl_vec_t MASKABLE  = 16'hFFE0;

    typedef enum logic {S_IDLE, S_NEST} svc_state_e;

    function automatic logic [LVL_W-1:0] low_idx(lvl_vec_t v);
        logic [LVL_W-1:0] idx;
        idx = '0;
        for (int i = NLVL - 1; i >= 0; i--) begin
            if (v[i]) idx = LVL_W'(i);
        end
        return idx;
    endfunction
endpackage

// File: rtl/evt_route.sv
module evt_route import evt_pkg::*; #(
    parameter int NUM_SRC = 8,
    parameter int SRC_W   = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_req,
    input  logic               cfg_we,
    input  logic [SRC_W-1:0]   cfg_src,
    input  logic [LVL_W-1:0]   cfg_level,
    output logic [NPER-1:0]    lvl_req
);
    logic [OFS_W-1:0] route_q [NUM_SRC];
    logic             cfg_ok;

    assign cfg_ok = cfg_we && (cfg_level >= LVL_W'(PER_LO)) && (cfg_level <= LVL_W'(PER_HI));

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n)
                route_q[i] <= OFS_W'(i % NPER);
            else if (cfg_ok && cfg_src == SRC_W'(i))
                route_q[i] <= OFS_W'(cfg_level - LVL_W'(PER_LO));
        end

        // R10: an accepted write lands in the addressed entry
        a_r10_route_write: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_ok && cfg_src == SRC_W'(i)) |=>
                (route_q[i] == OFS_W'($past(cfg_level) - LVL_W'(PER_LO))));
    end

    always_comb begin
        lvl_req = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (src_req[i]) lvl_req[route_q[i]] = 1'b1;
        end
    end
endmodule

// File: rtl/evt_arbiter.sv
module evt_arbiter import evt_pkg::*; (
    input  lvl_vec_t         pend,
    input  lvl_vec_t         enable,
    input  lvl_vec_t         active,
    input  logic             block,
    output logic             take,
    output logic [LVL_W-1:0] level
);
    lvl_vec_t outranks;
    lvl_vec_t elig;
    logic     busy;

    always_comb begin
        busy = 1'b0;
        for (int l = 0; l < NLVL; l++) begin
            busy        = busy | active[l];
            outranks[l] = !busy;
        end
    end

    assign elig  = pend & enable & outranks;
    assign take  = (|elig) && !block;
    assign level = low_idx(elig);
endmodule

// File: rtl/evt_retslot.sv
module evt_retslot import evt_pkg::*; #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [LVL_W-1:0]  wr_lvl,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [LVL_W-1:0]  rd_lvl,
    input  logic              rd_vld,
    output logic [ADDR_W-1:0] rd_addr
);
    logic [ADDR_W-1:0] slot_q [NLVL];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NLVL; i++) slot_q[i] <= '0;
        end else if (wr_en) begin
            slot_q[wr_lvl] <= wr_addr;
        end
    end

    assign rd_addr = rd_vld ? slot_q[rd_lvl] : '0;
endmodule

// File: rtl/evt_nest_ctrl.sv
module evt_nest_ctrl import evt_pkg::*; #(
    parameter int NUM_SRC = 8,
    parameter int ADDR_W  = 32,
    localparam int SRC_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               emu_req,
    input  logic               rst_evt_req,
    input  logic               nmi_pin,
    input  logic               wdog_expire,
    input  logic               exc_req,
    input  logic               hwerr_req,
    input  logic               tmr_req,
    input  logic [NUM_SRC-1:0] periph_req,
    input  logic [1:0]         swi_raise,
    input  logic               mask_we,
    input  logic [NLVL-1:0]    mask_wdata,
    input  logic               cfg_we,
    input  logic [SRC_W-1:0]   cfg_src,
    input  logic [LVL_W-1:0]   cfg_level,
    input  logic               rfe,
    input  logic [ADDR_W-1:0]  ret_addr_in,
    output logic               evt_take,
    output logic [LVL_W-1:0]   evt_level,
    output logic               kill_insn,
    output logic               in_service,
    output logic [NLVL-1:0]    active_vec,
    output logic [NLVL-1:0]    pending_vec,
    output logic [ADDR_W-1:0]  ret_addr_out
);
    lvl_vec_t         raw_req, pend_q, pend_d, act_q, act_d, mask_q, enable;
    lvl_vec_t         take_1h, ret_1h;
    logic [NPER-1:0]  per_lvl;
    logic [LVL_W-1:0] top_lvl;
    logic             top_vld;
    logic             blk;
    svc_state_e       st_q, st_d;

    evt_route #(.NUM_SRC(NUM_SRC), .SRC_W(SRC_W)) u_route (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_req   (periph_req),
        .cfg_we    (cfg_we),
        .cfg_src   (cfg_src),
        .cfg_level (cfg_level),
        .lvl_req   (per_lvl)
    );

    assign raw_req = {swi_raise, per_lvl, tmr_req, hwerr_req, 1'b0,
                      exc_req, nmi_pin | wdog_expire, rst_evt_req, emu_req};
    assign enable  = mask_q | ALWAYS_ON;

    evt_arbiter u_arb (
        .pend   (pend_q),
        .enable (enable),
        .active (act_q),
        .block  (blk),
        .take   (evt_take),
        .level  (evt_level)
    );

    assign top_lvl = low_idx(act_q);
    assign top_vld = |act_q;
    assign take_1h = evt_take ? (lvl_vec_t'(1) << evt_level) : '0;
    assign ret_1h  = blk ? (lvl_vec_t'(1) << top_lvl) : '0;
    assign pend_d  = (pend_q & ~take_1h) | raw_req;
    assign act_d   = (act_q & ~ret_1h) | take_1h;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
            act_q  <= '0;
            mask_q <= '0;
        end else begin
            pend_q <= pend_d;
            act_q  <= act_d;
            if (mask_we) mask_q <= mask_wdata & MASKABLE;
        end
    end

    evt_retslot #(.ADDR_W(ADDR_W)) u_slot (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (evt_take),
        .wr_lvl  (evt_level),
        .wr_addr (ret_addr_in),
        .rd_lvl  (top_lvl),
        .rd_vld  (top_vld),
        .rd_addr (ret_addr_out)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= S_IDLE;
        else        st_q <= st_d;
    end

    // transitions: T_ENTER, T_DEEPER, T_UNWIND, T_DONE
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            S_IDLE: if (evt_take) st_d = S_NEST;
            S_NEST: if (rfe && $countones(act_q) == 1) st_d = S_IDLE;
            default: st_d = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        in_service = 1'b0;
        blk        = 1'b0;
        unique case (st_q)
            S_IDLE: begin
                in_service = 1'b0;
                blk        = 1'b0;
            end
            S_NEST: begin
                in_service = 1'b1;
                blk        = rfe;
            end
            default: ;
        endcase
        kill_insn = exc_req;
    end

    assign active_vec  = act_q;
    assign pending_vec = pend_q;

    // R4: an entry outranks every active level
    a_r4_strict_rank: assert property (@(posedge clk) disable iff (!rst_n)
        evt_take |-> ((act_q & ((lvl_vec_t'(2) << evt_level) - lvl_vec_t'(1))) == '0));

    // R3: a disabled level is never entered
    a_r3_mask_gate: assert property (@(posedge clk) disable iff (!rst_n)
        evt_take |-> (evt_level < LVL_W'(4) || mask_q[evt_level]));

    // R5: entry makes the level active and consumes its request
    a_r5_enter: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_take && !raw_req[evt_level]) |=> (act_q[$past(evt_level)] && !pend_q[$past(evt_level)]));

    // R6: a return removes exactly one active level
    a_r6_unwind: assert property (@(posedge clk) disable iff (!rst_n)
        blk |=> ($countones(act_q) + 1 == $countones($past(act_q))));

    // R2: the reserved level stays silent
    a_r2_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        !pend_q[4] && !act_q[4]);

    // R11: state agrees with the active set
    a_r11_state: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_NEST) == (act_q != '0));
endmodule

// File: tb/evt_nest_ctrl_tb_top.sv
`timescale 1ns/1ps
module evt_nest_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        emu_req = 0, rst_evt_req = 0, nmi_pin = 0, wdog_expire = 0;
    logic        exc_req = 0, hwerr_req = 0, tmr_req = 0;
    logic [7:0]  periph_req = '0;
    logic [1:0]  swi_raise = '0;
    logic        mask_we = 0;
    logic [15:0] mask_wdata = '0;
    logic        cfg_we = 0;
    logic [2:0]  cfg_src = '0;
    logic [3:0]  cfg_level = '0;
    logic        rfe = 0;
    logic [31:0] ret_addr_in = '0;
    logic        evt_take, kill_insn, in_service;
    logic [3:0]  evt_level;
    logic [15:0] active_vec, pending_vec;
    logic [31:0] ret_addr_out;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    int exp_q[$];

    always #4 clk = ~clk;

    evt_nest_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .emu_req(emu_req), .rst_evt_req(rst_evt_req),
        .nmi_pin(nmi_pin), .wdog_expire(wdog_expire), .exc_req(exc_req),
        .hwerr_req(hwerr_req), .tmr_req(tmr_req), .periph_req(periph_req),
        .swi_raise(swi_raise), .mask_we(mask_we), .mask_wdata(mask_wdata),
        .cfg_we(cfg_we), .cfg_src(cfg_src), .cfg_level(cfg_level), .rfe(rfe),
        .ret_addr_in(ret_addr_in), .evt_take(evt_take), .evt_level(evt_level),
        .kill_insn(kill_insn), .in_service(in_service), .active_vec(active_vec),
        .pending_vec(pending_vec), .ret_addr_out(ret_addr_out)
    );

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic expect_evt(int lvl);
        exp_q.push_back(lvl);
    endtask

    task automatic retire();
        rfe = 1; tick(); rfe = 0; tick();
    endtask

    task automatic write_mask(logic [15:0] m);
        mask_we = 1; mask_wdata = m; tick(); mask_we = 0;
    endtask

    // monitor: compares each entry with the scoreboard
    always @(negedge clk) begin
        if (rst_n && evt_take && !done) begin
            checks++;
            if (exp_q.size() == 0) begin
                failures++;
                $display("FAIL R4 unexpected entry actual=%0d expected=none", evt_level);
            end else begin
                int e;
                e = exp_q.pop_front();
                if (int'(evt_level) != e) begin
                    failures++;
                    $display("FAIL R4 entry order actual=%0d expected=%0d", evt_level, e);
                end
            end
        end
    end

    task automatic report();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        report();
    end

    initial begin
        repeat (3) tick();
        // R1: reset state
        chk("R1 pending", pending_vec, 0);
        chk("R1 active", active_vec, 0);
        chk("R1 take", evt_take, 0);
        rst_n = 1; tick();
        chk("R1 in_service", in_service, 0);
        // R3: maskable levels disabled after reset; R2 timer pends
        tmr_req = 1; tick(); tmr_req = 0; tick();
        chk("R3 masked timer pending", pending_vec[6], 1);
        chk("R3 masked timer not active", active_vec, 0);
        // R3: enabling releases the held request
        expect_evt(6); ret_addr_in = 32'h100;
        write_mask(16'hFFFF); tick();
        chk("R5 timer active", active_vec, 16'h0040);
        chk("R11 in_service", in_service, 1);
        chk("R7 slot of level 6", ret_addr_out, 32'h100);
        // R4: lower priority peripheral waits (R10 default source 0 -> 7)
        periph_req[0] = 1; tick(); periph_req[0] = 0; tick();
        chk("R4 level 7 held", pending_vec[7], 1);
        chk("R4 level 7 not active", active_vec[7], 0);
        // nested higher priority entry
        expect_evt(5); ret_addr_in = 32'h200;
        hwerr_req = 1; tick(); hwerr_req = 0; tick();
        chk("R5 nested active", active_vec, 16'h0060);
        chk("R7 slot of level 5", ret_addr_out, 32'h200);
        rfe = 1; tick(); rfe = 0;
        chk("R6 retire top", active_vec, 16'h0040);
        chk("R7 unwound slot", ret_addr_out, 32'h100);
        expect_evt(7); ret_addr_in = 32'h300;
        retire();
        chk("R6 level 7 entered after unwind", active_vec, 16'h0080);
        retire();
        chk("R11 idle", in_service, 0);
        chk("R7 idle slot", ret_addr_out, 0);
        // R4: simultaneous requests served in level order
        expect_evt(0); expect_evt(2); expect_evt(6); expect_evt(15);
        emu_req = 1; nmi_pin = 1; tmr_req = 1; swi_raise = 2'b10; tick();
        emu_req = 0; nmi_pin = 0; tmr_req = 0; swi_raise = 0;
        chk("R2 reserved level never pends", pending_vec[4], 0);
        chk("R2 pend set", pending_vec, 16'h8045);
        tick();
        chk("R4 emulation first", active_vec, 16'h0001);
        retire(); retire(); retire(); retire();
        chk("R4 all served", active_vec, 0);
        // R2: watchdog, reset event, exception, swi 14
        expect_evt(2); wdog_expire = 1; tick(); wdog_expire = 0; tick(); retire();
        expect_evt(1); rst_evt_req = 1; tick(); rst_evt_req = 0; tick(); retire();
        expect_evt(14); swi_raise = 2'b01; tick(); swi_raise = 0; tick(); retire();
        // R3 unmaskable with mask zero; R9 kill
        write_mask(16'h0000);
        chk("R9 kill idle", kill_insn, 0);
        expect_evt(3); exc_req = 1; #1;
        chk("R9 kill with exception", kill_insn, 1);
        tick(); exc_req = 0; #1;
        chk("R9 kill drops", kill_insn, 0);
        tick(); retire();
        // R3: masked peripheral level 9 (default source 2) held
        write_mask(16'hFDFF);
        periph_req[2] = 1; tick(); periph_req[2] = 0; tick(); tick();
        chk("R3 masked level 9 held", pending_vec[9], 1);
        chk("R3 masked level not taken", active_vec, 0);
        expect_evt(9); write_mask(16'hFFFF); tick(); retire();
        // R8: same-level request waits for retirement
        expect_evt(6); tmr_req = 1; tick(); tmr_req = 0; tick();
        tmr_req = 1; tick(); tmr_req = 0; tick();
        chk("R8 same level pending", pending_vec[6], 1);
        chk("R8 not re-entered", active_vec, 16'h0040);
        expect_evt(6); retire();
        chk("R8 re-entered", active_vec, 16'h0040);
        retire();
        // R10: reroute source 3 to 12, invalid write ignored
        cfg_we = 1; cfg_src = 3; cfg_level = 12; tick();
        cfg_src = 3; cfg_level = 14; tick(); cfg_we = 0;
        expect_evt(12); periph_req[3] = 1; tick(); periph_req[3] = 0; tick();
        chk("R10 rerouted level", active_vec, 16'h1000);
        retire();
        expect_evt(7); periph_req[7] = 1; tick(); periph_req[7] = 0; tick();
        chk("R10 default source 7", active_vec, 16'h0080);
        retire();
        // R6: return while idle ignored
        rfe = 1; tick(); rfe = 0; tick();
        chk("R6 idle rfe active", active_vec, 0);
        chk("R6 idle rfe state", in_service, 0);
        expect_evt(6); tmr_req = 1; tick(); tmr_req = 0; tick();
        chk("R6 entry after idle rfe", active_vec, 16'h0040);
        retire();
        repeat (2) tick();
        chk("R4 scoreboard drained", exp_q.size(), 0);
        report();
    end
endmodule